// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block serves the single-register memory access path of a processor core. For each request it forms an unsigned offset, adds it to or subtracts it from the supplied base value, and picks the access address. With pre-indexing the address is the adjusted value. With post-indexing the address is the base itself. The block also reports whether the base register must be rewritten, and with what value. The offset comes either from a 12-bit immediate or from a register value shifted left by a 5-bit amount; a shift of zero gives a plain register offset.

Every request is checked against the alignment of its access size. A request that uses the program counter as its offset register is refused. Either problem stops the memory request and the base update. Results are registered, one cycle after the request. A load formatter then takes a 32-bit read word and returns the addressed byte or half-word, zero- or sign-extended. It uses the address and size of the most recent accepted request.

Top module: `lsu_agen`

## Requirements
- R1: When `req_use_reg` is 0 the offset is `req_imm` zero-extended, a magnitude of 0 to 4095; `req_reg_val`, `req_reg_idx` and `req_shift` have no effect on any output.
- R2: When `req_use_reg` is 1 the offset is `req_reg_val` shifted left by `req_shift` (0 to 31), and bits shifted past bit 31 are lost.
- R3: With `req_up` = 1 the adjusted value is base + offset; with `req_up` = 0 it is base - offset; both wrap modulo 2^32.
- R4: With `req_pre` = 1, `addr_o` is the adjusted value. `base_wr_o` is 1 only when `req_wb` = 1, and `base_val_o` then equals `addr_o`.
- R5: With `req_pre` = 0, `addr_o` is the unmodified base. `base_wr_o` is 1 whatever `req_wb` is, and `base_val_o` is the adjusted value.
- R6: `req_size` encodes 0 word, 1 unsigned byte, 2 signed byte, 3 unsigned half-word, 4 signed half-word. A word access needs address bits [1:0] = 0 and a half-word access needs bit 0 = 0. A violation sets `align_fault_o` and forces `mem_req_o`, `mem_we_o` and `base_wr_o` to 0.
- R7: A register offset (`req_use_reg` = 1) with `req_reg_idx` = 15 sets `illegal_o`, forces `mem_req_o`, `mem_we_o`, `base_wr_o` and `align_fault_o` to 0, and takes priority over an alignment fault.
- R8: All outputs except `ld_data_o` are registered and show a request one clock after it is presented with `req_valid` = 1. A cycle with `req_valid` = 0 gives `mem_req_o`, `mem_we_o`, `base_wr_o`, `align_fault_o` and `illegal_o` all 0. After reset all outputs are 0.
- R9: `ld_data_o` is combinational from `rdata_i`, using the registered address and size. Byte lane k (selected by address bits [1:0]) is `rdata_i[8k+7:8k]`. Address bit 1 selects the half-word `rdata_i[31:16]` when 1 and `rdata_i[15:0]` when 0. A word passes unchanged. Signed sizes are sign-extended to 32 bits and unsigned sizes are zero-extended.
- R10: `mem_we_o` is 1 exactly when `mem_req_o` is 1 and the request was a store (`req_load` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_load | input | 1 | 1 load, 0 store |
| req_base | input | 32 | Base register value |
| req_use_reg | input | 1 | 1 register offset, 0 immediate offset |
| req_imm | input | 12 | Immediate offset magnitude |
| req_reg_val | input | 32 | Offset register value |
| req_reg_idx | input | 4 | Offset register number (15 is the program counter) |
| req_shift | input | 5 | Left-shift amount for the register offset |
| req_up | input | 1 | 1 add offset, 0 subtract |
| req_pre | input | 1 | 1 pre-index, 0 post-index |
| req_wb | input | 1 | Write-back request for pre-index |
| req_size | input | 3 | Access size and signedness code |
| rdata_i | input | 32 | Read word from memory |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| addr_o | output | 32 | Access address |
| align_fault_o | output | 1 | Address misaligned for size |
| illegal_o | output | 1 | Program counter named as offset register |
| base_wr_o | output | 1 | Base register write enable |
| base_val_o | output | 32 | New base value |
| ld_data_o | output | 32 | Extracted and extended load data |

## Verification
The hardest case to reach is a request that is both illegal and misaligned. Another is a post-index request whose unmodified base is misaligned while the adjusted value is aligned, because the fault must follow the access address and not the write-back value. Random bases make about three quarters of word accesses misaligned, and about one register offset in sixteen names register 15, so these cases occur together many times. Directed cases pin a PC-indexed misaligned word and a post-index access from an odd base. Sign extension is tested with lanes whose top bit is set in each byte and half-word position.

// File: rtl/lsu_agen_pkg.sv
package lsu_agen_pkg;

    typedef enum logic [2:0] {
        SZ_WORD  = 3'd0,
        SZ_UBYTE = 3'd1,
        SZ_SBYTE = 3'd2,
        SZ_UHALF = 3'd3,
        SZ_SHALF = 3'd4
    } size_e;

    function automatic logic is_half(input size_e s);
        return (s == SZ_UHALF) || (s == SZ_SHALF);
    endfunction

    function automatic logic is_byte(input size_e s);
        return (s == SZ_UBYTE) || (s == SZ_SBYTE);
    endfunction

endpackage

// File: rtl/lsu_offset_unit.sv
module lsu_offset_unit #(
    parameter int AW     = 32,
    parameter int IMM_W  = 12,
    parameter int SH_W   = 5,
    parameter int RIDX_W = 4,
    parameter int PC_IDX = 15
) (
    input  logic              use_reg,
    input  logic [IMM_W-1:0]  imm,
    input  logic [AW-1:0]     reg_val,
    input  logic [RIDX_W-1:0] reg_idx,
    input  logic [SH_W-1:0]   shamt,
    output logic [AW-1:0]     offset,
    output logic              illegal
);
    localparam int PAD_W = AW - IMM_W;
    localparam logic [RIDX_W-1:0] PC_CODE = RIDX_W'(PC_IDX);

    logic [AW-1:0] imm_ext;
    logic [AW-1:0] reg_scaled;

    always_comb begin
        imm_ext    = {{PAD_W{1'b0}}, imm};
        reg_scaled = reg_val << shamt;
        offset     = use_reg ? reg_scaled : imm_ext;
        illegal    = use_reg && (reg_idx == PC_CODE);
    end
endmodule

// File: rtl/lsu_addr_calc.sv
module lsu_addr_calc
    import lsu_agen_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] offset,
    input  logic          up,
    input  logic          pre,
    input  logic          wb,
    input  size_e         size,
    output logic [AW-1:0] acc_addr,
    output logic [AW-1:0] adj_base,
    output logic          wb_req,
    output logic          misalign
);
    always_comb begin
        adj_base = up ? (base + offset) : (base - offset);
        acc_addr = pre ? adj_base : base;
        wb_req   = !pre || wb;
        if (size == SZ_WORD) begin
            misalign = |acc_addr[1:0];
        end else if (is_half(size)) begin
            misalign = acc_addr[0];
        end else begin
            misalign = 1'b0;
        end
    end
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
    import lsu_agen_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]              rdata,
    input  logic [$clog2(DW/8)-1:0]    lane,
    input  size_e                      size,
    output logic [DW-1:0]              data
);
    localparam int LANES  = DW / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int HALVES = LANES / 2;

    logic [7:0]  byte_v [LANES];
    logic [15:0] half_v [HALVES];

    for (genvar g = 0; g < LANES; g++) begin : g_byte
        assign byte_v[g] = rdata[8*g +: 8];
    end
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign half_v[h] = rdata[16*h +: 16];
    end

    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    always_comb begin
        sel_b = byte_v[lane];
        sel_h = half_v[lane[LANE_W-1:1]];
        unique case (size)
            SZ_UBYTE: data = {{(DW-8){1'b0}}, sel_b};
            SZ_SBYTE: data = {{(DW-8){sel_b[7]}}, sel_b};
            SZ_UHALF: data = {{(DW-16){1'b0}}, sel_h};
            SZ_SHALF: data = {{(DW-16){sel_h[15]}}, sel_h};
            default:  data = rdata;
        endcase
    end
endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_agen_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int IMM_W  = 12,
    parameter int SH_W   = 5,
    parameter int RIDX_W = 4,
    parameter int PC_IDX = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_load,
    input  logic [AW-1:0]     req_base,
    input  logic              req_use_reg,
    input  logic [IMM_W-1:0]  req_imm,
    input  logic [AW-1:0]     req_reg_val,
    input  logic [RIDX_W-1:0] req_reg_idx,
    input  logic [SH_W-1:0]   req_shift,
    input  logic              req_up,
    input  logic              req_pre,
    input  logic              req_wb,
    input  logic [2:0]        req_size,
    input  logic [DW-1:0]     rdata_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     addr_o,
    output logic              align_fault_o,
    output logic              illegal_o,
    output logic              base_wr_o,
    output logic [AW-1:0]     base_val_o,
    output logic [DW-1:0]     ld_data_o
);
    localparam int LANE_W = $clog2(DW / 8);

    typedef struct packed {
        logic          mem_req;
        logic          mem_we;
        logic [AW-1:0] addr;
        logic          fault;
        logic          illegal;
        logic          base_wr;
        logic [AW-1:0] base_val;
        size_e         size;
    } agen_state_t;

    agen_state_t st_d, st_q;

    size_e         size_in;
    logic [AW-1:0] offset;
    logic          off_illegal;
    logic [AW-1:0] acc_addr;
    logic [AW-1:0] adj_base;
    logic          wb_req;
    logic          misalign;

    assign size_in = size_e'(req_size);

    lsu_offset_unit #(
        .AW(AW), .IMM_W(IMM_W), .SH_W(SH_W), .RIDX_W(RIDX_W), .PC_IDX(PC_IDX)
    ) i_offset (
        .use_reg (req_use_reg),
        .imm     (req_imm),
        .reg_val (req_reg_val),
        .reg_idx (req_reg_idx),
        .shamt   (req_shift),
        .offset  (offset),
        .illegal (off_illegal)
    );

    lsu_addr_calc #(.AW(AW)) i_calc (
        .base     (req_base),
        .offset   (offset),
        .up       (req_up),
        .pre      (req_pre),
        .wb       (req_wb),
        .size     (size_in),
        .acc_addr (acc_addr),
        .adj_base (adj_base),
        .wb_req   (wb_req),
        .misalign (misalign)
    );

    always_comb begin
        logic ok;
        st_d         = st_q;
        st_d.mem_req = 1'b0;
        st_d.mem_we  = 1'b0;
        st_d.fault   = 1'b0;
        st_d.illegal = 1'b0;
        st_d.base_wr = 1'b0;
        ok           = !off_illegal && !misalign;
        if (req_valid) begin
            st_d.addr     = acc_addr;
            st_d.size     = size_in;
            st_d.illegal  = off_illegal;
            st_d.fault    = !off_illegal && misalign;
            st_d.mem_req  = ok;
            st_d.mem_we   = ok && !req_load;
            st_d.base_wr  = ok && wb_req;
            st_d.base_val = adj_base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mem_req: 1'b0, mem_we: 1'b0, addr: '0, fault: 1'b0,
                      illegal: 1'b0, base_wr: 1'b0, base_val: '0, size: SZ_WORD};
        end else begin
            st_q <= st_d;
        end
    end

    lsu_load_fmt #(.DW(DW)) i_fmt (
        .rdata (rdata_i),
        .lane  (st_q.addr[LANE_W-1:0]),
        .size  (st_q.size),
        .data  (ld_data_o)
    );

    assign mem_req_o     = st_q.mem_req;
    assign mem_we_o      = st_q.mem_we;
    assign addr_o        = st_q.addr;
    assign align_fault_o = st_q.fault;
    assign illegal_o     = st_q.illegal;
    assign base_wr_o     = st_q.base_wr;
    assign base_val_o    = st_q.base_val;
endmodule

// File: rtl/lsu_agen_chk.sv
module lsu_agen_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_pre,
    input logic [2:0]    req_size,
    input logic [AW-1:0] req_base,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] addr_o,
    input logic          align_fault_o,
    input logic          illegal_o,
    input logic          base_wr_o,
    input logic [AW-1:0] base_val_o
);
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> !mem_req_o && !mem_we_o && !base_wr_o && !align_fault_o && !illegal_o);

    // R6
    fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault_o |-> !mem_req_o && !base_wr_o && !mem_we_o);

    // R7
    illegal_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !mem_req_o && !base_wr_o && !align_fault_o);

    // R10
    write_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> mem_req_o);

    // R5
    post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !$past(req_pre)) |-> (addr_o == $past(req_base)) && base_wr_o);

    // R4
    pre_wb_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr_o && $past(req_pre)) |-> base_val_o == addr_o);

    // R6
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && $past(req_size) == 3'd0) |-> addr_o[1:0] == 2'b00);

    // R6
    half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && ($past(req_size) == 3'd3 || $past(req_size) == 3'd4)) |-> !addr_o[0]);
endmodule

bind lsu_agen lsu_agen_chk #(.AW(AW)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_pre       (req_pre),
    .req_size      (req_size),
    .req_base      (req_base),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .addr_o        (addr_o),
    .align_fault_o (align_fault_o),
    .illegal_o     (illegal_o),
    .base_wr_o     (base_wr_o),
    .base_val_o    (base_val_o)
);

// File: tb/test_lsu_agen.sv
module test_lsu_agen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_load = 1'b0;
    logic [31:0] req_base = '0;
    logic        req_use_reg = 1'b0;
    logic [11:0] req_imm = '0;
    logic [31:0] req_reg_val = '0;
    logic [3:0]  req_reg_idx = '0;
    logic [4:0]  req_shift = '0;
    logic        req_up = 1'b0;
    logic        req_pre = 1'b0;
    logic        req_wb = 1'b0;
    logic [2:0]  req_size = '0;
    logic [31:0] rdata_i = '0;
    logic        mem_req_o, mem_we_o, align_fault_o, illegal_o, base_wr_o;
    logic [31:0] addr_o, base_val_o, ld_data_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_agen i_lsu_agen (.*);

    task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] fmt_model(input logic [31:0] w, input logic [1:0] a, input logic [2:0] s);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[8*a +: 8];
        h = a[1] ? w[31:16] : w[15:0];
        case (s)
            3'd1:    return {24'h0, b};
            3'd2:    return {{24{b[7]}}, b};
            3'd3:    return {16'h0, h};
            3'd4:    return {{16{h[15]}}, h};
            default: return w;
        endcase
    endfunction

    task automatic run_req(input logic ld, input logic [31:0] base, input logic use_reg,
                           input logic [11:0] imm, input logic [31:0] rval, input logic [3:0] ridx,
                           input logic [4:0] sh, input logic up, input logic pre, input logic wb,
                           input logic [2:0] size, input logic [31:0] rword);
        logic [31:0] off, sum, acc;
        logic ill, mis, e_req, e_bwr;
        @(negedge clk);
        req_valid = 1'b1; req_load = ld; req_base = base; req_use_reg = use_reg;
        req_imm = imm; req_reg_val = rval; req_reg_idx = ridx; req_shift = sh;
        req_up = up; req_pre = pre; req_wb = wb; req_size = size;
        off   = use_reg ? (rval << sh) : {20'h0, imm};
        ill   = use_reg && (ridx == 4'd15);
        sum   = up ? base + off : base - off;
        acc   = pre ? sum : base;
        mis   = (size == 3'd0 && acc[1:0] != 2'b00) || ((size == 3'd3 || size == 3'd4) && acc[0]);
        e_req = !ill && !mis;
        e_bwr = e_req && (!pre || wb);
        @(posedge clk);
        #1;
        check("R7", "illegal", {63'h0, illegal_o}, {63'h0, ill});
        check("R6", "align_fault", {63'h0, align_fault_o}, {63'h0, !ill && mis});
        check("R6", "mem_req", {63'h0, mem_req_o}, {63'h0, e_req});
        check("R10", "mem_we", {63'h0, mem_we_o}, {63'h0, e_req && !ld});
        if (!ill) check(pre ? "R4" : "R5", "addr", {32'h0, addr_o}, {32'h0, acc});
        check(pre ? "R4" : "R5", "base_wr", {63'h0, base_wr_o}, {63'h0, e_bwr});
        if (e_bwr) check("R3", "base_val", {32'h0, base_val_o}, {32'h0, sum});
        if (e_req && ld) begin
            rdata_i = rword;
            #1;
            check("R9", "ld_data", {32'h0, ld_data_o}, {32'h0, fmt_model(rword, acc[1:0], size)});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        check("R8", "reset mem_req", {63'h0, mem_req_o}, 64'h0);
        check("R8", "reset base_wr", {63'h0, base_wr_o}, 64'h0);
        check("R8", "reset addr", {32'h0, addr_o}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: immediate offset, pre-index with write-back
        run_req(1'b0, 32'h200, 1'b0, 12'd12, 32'hFFFF_FFFF, 4'd15, 5'd7, 1'b1, 1'b1, 1'b1, 3'd0, 32'h0);
        // R1 and R3: maximum immediate, subtract, wraps below zero
        run_req(1'b1, 32'h0000_0100, 1'b0, 12'hFFF, 32'h0, 4'd0, 5'd0, 1'b0, 1'b1, 1'b0, 3'd1, 32'hA1B2_C3D4);
        // R2: register 3 shifted by 2 gives 12
        run_req(1'b0, 32'h200, 1'b1, 12'h0, 32'd3, 4'd2, 5'd2, 1'b1, 1'b1, 1'b0, 3'd0, 32'h0);
        // R2: bits shifted out are lost
        run_req(1'b0, 32'h1000, 1'b1, 12'h0, 32'hC000_0001, 4'd4, 5'd31, 1'b1, 1'b1, 1'b1, 3'd1, 32'h0);
        // R5: post-index writes back with wb=0, address is base
        run_req(1'b1, 32'h200, 1'b0, 12'd12, 32'h0, 4'd0, 5'd0, 1'b1, 1'b0, 1'b0, 3'd0, 32'h1234_5678);
        // R5: odd base misaligned for half although adjusted base is even
        run_req(1'b1, 32'h201, 1'b0, 12'd1, 32'h0, 4'd0, 5'd0, 1'b1, 1'b0, 1'b0, 3'd3, 32'h0);
        // R6: misaligned word via pre-index
        run_req(1'b0, 32'h200, 1'b0, 12'd2, 32'h0, 4'd0, 5'd0, 1'b1, 1'b1, 1'b1, 3'd0, 32'h0);
        // R7: PC offset register and misaligned together
        run_req(1'b1, 32'h203, 1'b1, 12'h0, 32'd0, 4'd15, 5'd0, 1'b1, 1'b1, 1'b1, 3'd0, 32'h0);
        // R9: sign extension in upper byte and upper half lanes
        run_req(1'b1, 32'h303, 1'b0, 12'd0, 32'h0, 4'd0, 5'd0, 1'b1, 1'b1, 1'b0, 3'd2, 32'h80FF_7F01);
        run_req(1'b1, 32'h302, 1'b0, 12'd0, 32'h0, 4'd0, 5'd0, 1'b1, 1'b1, 1'b0, 3'd4, 32'h8001_7FFF);
        run_req(1'b1, 32'h300, 1'b0, 12'd0, 32'h0, 4'd0, 5'd0, 1'b1, 1'b1, 1'b0, 3'd4, 32'h0000_9234);

        // R8: idle cycle gives no request
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R8", "idle mem_req", {63'h0, mem_req_o}, 64'h0);
        check("R8", "idle base_wr", {63'h0, base_wr_o}, 64'h0);
        check("R8", "idle faults", {62'h0, align_fault_o, illegal_o}, 64'h0);

        for (int i = 0; i < 400; i++) begin
            run_req($urandom_range(1, 0) == 1, $urandom, $urandom_range(1, 0) == 1,
                    12'($urandom), $urandom, 4'($urandom), 5'($urandom),
                    $urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1,
                    3'($urandom_range(4, 0)), $urandom);
        end

        @(negedge clk);
        req_valid = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule